// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block sits behind a UART receiver and turns its stream of bytes into HDLC frames. A frame is the run of bytes between two flag bytes (0x7E). Inside a frame, an escape byte (0x7D) is dropped and the byte after it is restored by XOR with 0x20. The block checks a reflected CRC-16 or CRC-32 over each frame. It can keep only frames whose leading address byte, or leading address pair, matches a programmed value. Accepted bytes leave on a valid/data/end-of-frame interface. The end-of-frame beat carries two flags: CRC failure and abort.

The block holds the most recent five data bytes in a shift register. This lets it do three things: decide the address before any byte leaves, remove the 2 or 4 CRC bytes when the closing flag shows where the frame ends, and attach end-of-frame to a real data byte. With the receive enable low, all framing state is cleared and nothing is delivered, so the UART can run as a plain character receiver. The upstream byte source must leave at least six clock cycles between successive bytes. A UART at any practical baud rate does so by a wide margin.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While `rx_en` is low, `out_valid` stays low. Any partly received frame is discarded, and the next frame needs a fresh opening flag.
- R2: Bytes seen before the first flag after enable are ignored. Back-to-back flags with no data between them produce no output.
- R3: Inside a frame, byte 0x7D is removed, and the next non-flag byte is XORed with 0x20 before address matching, the CRC and the output.
- R4: With `addr_mode` 2'b00 or 2'b11, every frame is accepted.
- R5: With `addr_mode` 2'b01, a frame is accepted only if its first byte equals one of the four bytes of `addr_cfg` (byte k at bits [8k+7:8k]).
- R6: With `addr_mode` 2'b10, a frame is accepted only if {first byte, second byte} equals `addr_cfg[15:0]` or `addr_cfg[31:16]`. A frame shorter than two bytes is rejected.
- R7: With `crc_en` high, the CRC runs over every data byte, including the received CRC. `crc_size` 0 selects the reflected CRC-16 (polynomial 0x8408, initial value 0xFFFF, good residue 0xF0B8). `crc_size` 1 selects the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF, good residue 0xDEBB20E3). Any other residue raises `out_crc_err` on the end-of-frame beat. With `crc_en` low it never rises.
- R8: With `crc_en` high and `crc_pass` low, the final 2 or 4 bytes of each frame are withheld. With `crc_pass` high, they are delivered after the payload.
- R9: An escape byte followed by a flag aborts the frame. All of its held bytes are released, and the last one carries `out_abort` with `out_crc_err` low.
- R10: `out_eof`, `out_crc_err` and `out_abort` are high only on the last delivered byte of a frame, and all outputs are low after reset.
- R11: A frame with no byte left after CRC removal produces no output at all.
- R12: Once a frame holds five data bytes, each further data byte releases the oldest one two cycles after that byte is presented. After the closing flag, the remaining bytes appear on consecutive cycles, starting two cycles after the flag is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Enables HDLC reception |
| crc_en | input | 1 | Enables the CRC check and CRC handling |
| crc_size | input | 1 | 0 = CRC-16, 1 = CRC-32 |
| crc_pass | input | 1 | 1 = deliver the received CRC bytes |
| addr_mode | input | 2 | Address filter mode |
| addr_cfg | input | 32 | Four address bytes or two address pairs |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_eof | output | 1 | Last byte of the frame |
| out_crc_err | output | 1 | Frame failed the CRC (on the end-of-frame beat) |
| out_abort | output | 1 | Frame was aborted (on the end-of-frame beat) |

## Verification
There are two register stages between a byte and its effect at the output: the unstuffing stage and the frame stage. A data byte that pushes out an older one shows up two cycles after it is driven. A closing flag starts its release two cycles later, and up to five bytes follow on back-to-back cycles. The bench stamps every driven byte and every delivered byte with a cycle count. It compares those stamps against these offsets for one frame long enough to overflow the hold buffer. Bytes are driven six cycles apart, and each frame is compared only after twelve quiet cycles, which is longer than the longest release. Content and status are therefore checked once the frame is final, and the latency check covers the exact timing.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [7:0]  FLAG_BYTE     = 8'h7E;
  localparam logic [7:0]  ESC_BYTE      = 8'h7D;
  localparam logic [7:0]  ESC_XOR       = 8'h20;
  localparam int          CRC_MAX_BYTES = 4;
  localparam logic [31:0] POLY16_REF    = 32'h0000_8408;
  localparam logic [31:0] POLY32_REF    = 32'hEDB8_8320;
  localparam logic [31:0] SEED16        = 32'h0000_FFFF;
  localparam logic [31:0] SEED32        = 32'hFFFF_FFFF;
  localparam logic [31:0] GOOD16        = 32'h0000_F0B8;
  localparam logic [31:0] GOOD32        = 32'hDEBB_20E3;

  typedef enum logic [1:0] {
    AM_ALL  = 2'b00,
    AM_BYTE = 2'b01,
    AM_PAIR = 2'b10,
    AM_RSVD = 2'b11
  } addr_mode_e;

  // One event per cycle from the unstuffing stage
  typedef struct packed {
    logic       data;
    logic       flag;
    logic       abort;
    logic [7:0] val;
  } rx_evt_t;

  // Reflected CRC over one byte; a 16-bit state lives in the low half
  function automatic logic [31:0] crc_step(input logic [31:0] c,
                                           input logic [7:0]  b,
                                           input logic        wide);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ (wide ? POLY32_REF : POLY16_REF)) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_unstuff.sv
module hdlc_rx_unstuff
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output rx_evt_t    evt
);

  logic in_frame;
  logic esc_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      in_frame <= 1'b0;
      esc_q    <= 1'b0;
      evt      <= '0;
    end else begin
      evt <= '0;
      if (in_valid) begin
        if (in_data == FLAG_BYTE) begin
          // a flag both closes the running frame and opens the next
          if (in_frame && esc_q) evt.abort <= 1'b1;
          else                   evt.flag  <= 1'b1;
          in_frame <= 1'b1;
          esc_q    <= 1'b0;
        end else if (in_frame) begin
          if (esc_q) begin
            evt.data <= 1'b1;
            evt.val  <= in_data ^ ESC_XOR;
            esc_q    <= 1'b0;
          end else if (in_data == ESC_BYTE) begin
            esc_q <= 1'b1;
          end else begin
            evt.data <= 1'b1;
            evt.val  <= in_data;
          end
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       step,
  input  logic [7:0] val,
  input  logic       wide,
  output logic       match
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= wide ? SEED32 : SEED16;
    else if (step)    crc_q <= crc_step(crc_q, val, wide);
  end

  assign match = wide ? (crc_q == GOOD32) : (crc_q == GOOD16);

endmodule

// File: rtl/hdlc_rx_addr_match.sv
module hdlc_rx_addr_match
  import hdlc_rx_pkg::*;
#(
  parameter int NUM_ADDR = 4
) (
  input  logic [1:0]            mode,
  input  logic [NUM_ADDR*8-1:0] cfg,
  input  logic [7:0]            first,
  input  logic [7:0]            second,
  input  logic                  have_first,
  input  logic                  have_second,
  output logic                  accept
);

  localparam int NUM_PAIR = NUM_ADDR / 2;

  logic [NUM_ADDR-1:0] byte_hit;
  logic [NUM_PAIR-1:0] pair_hit;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_byte
    assign byte_hit[g] = (cfg[8*g +: 8] == first);
  end

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    assign pair_hit[g] = (cfg[16*g +: 16] == {first, second});
  end

  always_comb begin
    case (addr_mode_e'(mode))
      AM_BYTE: accept = have_first && (|byte_hit);
      AM_PAIR: accept = have_second && (|pair_hit);
      default: accept = 1'b1;
    endcase
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int NUM_ADDR   = 4,
  parameter int HOLD_DEPTH = CRC_MAX_BYTES + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_en,
  input  logic                  crc_en,
  input  logic                  crc_size,
  input  logic                  crc_pass,
  input  logic [1:0]            addr_mode,
  input  logic [NUM_ADDR*8-1:0] addr_cfg,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic                  out_eof,
  output logic                  out_crc_err,
  output logic                  out_abort
);

  localparam int             CNT_W     = $clog2(HOLD_DEPTH + 1);
  localparam logic [CNT_W-1:0] HOLD_FULL = CNT_W'(HOLD_DEPTH);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  rx_evt_t          evt;
  logic [7:0]       hold [HOLD_DEPTH];
  logic [CNT_W-1:0] held;
  logic [CNT_W-1:0] drain_left;
  logic [CNT_W-1:0] strip_n;
  logic [CNT_W-1:0] rel_n;
  logic             spilled;
  logic [7:0]       a_first, a_second;
  logic             have_first, have_second;
  logic             accept;
  logic             crc_ok;
  logic             st_err, st_abt;
  logic             close_err;

  hdlc_rx_unstuff u_unstuff (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .evt      (evt)
  );

  hdlc_rx_fcs u_fcs (
    .clk   (clk),
    .rst   (rst),
    .clear (evt.flag || evt.abort || !rx_en),
    .step  (evt.data),
    .val   (evt.val),
    .wide  (crc_size),
    .match (crc_ok)
  );

  assign have_first  = (held >= CNT_W'(1)) || spilled;
  assign have_second = (held >= CNT_W'(2)) || spilled;

  hdlc_rx_addr_match #(.NUM_ADDR(NUM_ADDR)) u_addr (
    .mode        (addr_mode),
    .cfg         (addr_cfg),
    .first       (a_first),
    .second      (a_second),
    .have_first  (have_first),
    .have_second (have_second),
    .accept      (accept)
  );

  // bytes to withhold at the closing flag
  always_comb begin
    if (crc_en && !crc_pass) strip_n = crc_size ? CNT_W'(4) : CNT_W'(2);
    else                     strip_n = '0;
  end

  // bytes to release when the frame ends
  always_comb begin
    if (evt.abort)          rel_n = held;
    else if (held > strip_n) rel_n = held - strip_n;
    else                    rel_n = '0;
  end

  assign close_err = evt.flag && crc_en && !crc_ok;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      for (int i = 0; i < HOLD_DEPTH; i++) hold[i] <= '0;
      held        <= '0;
      drain_left  <= '0;
      spilled     <= 1'b0;
      a_first     <= '0;
      a_second    <= '0;
      st_err      <= 1'b0;
      st_abt      <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_eof     <= 1'b0;
      out_crc_err <= 1'b0;
      out_abort   <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_eof     <= 1'b0;
      out_crc_err <= 1'b0;
      out_abort   <= 1'b0;
      if (drain_left != '0) begin
        // release the tail of a closed frame, one byte per cycle
        out_valid <= 1'b1;
        out_data  <= hold[0];
        for (int i = 0; i < HOLD_DEPTH - 1; i++) hold[i] <= hold[i+1];
        drain_left <= drain_left - ONE;
        if (drain_left == ONE) begin
          out_eof     <= 1'b1;
          out_crc_err <= st_err;
          out_abort   <= st_abt;
          held        <= '0;
        end
      end else if (evt.data) begin
        if (!have_first)       a_first  <= evt.val;
        else if (!have_second) a_second <= evt.val;
        if (held == HOLD_FULL) begin
          if (accept) begin
            out_valid <= 1'b1;
            out_data  <= hold[0];
          end
          for (int i = 0; i < HOLD_DEPTH - 1; i++) hold[i] <= hold[i+1];
          hold[HOLD_DEPTH-1] <= evt.val;
          spilled <= 1'b1;
        end else begin
          hold[held] <= evt.val;
          held       <= held + ONE;
        end
      end else if (evt.flag || evt.abort) begin
        spilled <= 1'b0;
        if (accept && rel_n != '0) begin
          out_valid <= 1'b1;
          out_data  <= hold[0];
          for (int i = 0; i < HOLD_DEPTH - 1; i++) hold[i] <= hold[i+1];
          if (rel_n == ONE) begin
            out_eof     <= 1'b1;
            out_crc_err <= close_err;
            out_abort   <= evt.abort;
            held        <= '0;
          end else begin
            drain_left <= rel_n - ONE;
            st_err     <= close_err;
            st_abt     <= evt.abort;
          end
        end else begin
          held <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic out_valid,
  input logic out_eof,
  input logic out_crc_err,
  input logic out_abort
);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !out_valid); // R1

  AST_EOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> out_valid); // R10

  AST_STATUS_AT_EOF: assert property (@(posedge clk) disable iff (rst)
    (out_crc_err || out_abort) |-> out_eof); // R10

  AST_ABORT_NO_CRCERR: assert property (@(posedge clk) disable iff (rst)
    out_abort |-> !out_crc_err); // R9

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_en       (rx_en),
  .out_valid   (out_valid),
  .out_eof     (out_eof),
  .out_crc_err (out_crc_err),
  .out_abort   (out_abort)
);

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb;

  localparam int GAP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic        crc_en = 1'b0;
  logic        crc_size = 1'b0;
  logic        crc_pass = 1'b0;
  logic [1:0]  addr_mode = 2'b00;
  logic [31:0] addr_cfg = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_eof, out_crc_err, out_abort;

  always #10 clk = ~clk;

  hdlc_rx_deframer u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .crc_en(crc_en), .crc_size(crc_size),
    .crc_pass(crc_pass), .addr_mode(addr_mode), .addr_cfg(addr_cfg),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_eof(out_eof), .out_crc_err(out_crc_err),
    .out_abort(out_abort)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // output capture
  logic [7:0] o_data [512];
  bit         o_eof  [512];
  bit         o_err  [512];
  bit         o_abt  [512];
  int         o_cyc  [512];
  int         o_n = 0;

  always @(negedge clk) begin
    if (out_valid && o_n < 512) begin
      o_data[o_n] <= out_data;
      o_eof[o_n]  <= out_eof;
      o_err[o_n]  <= out_crc_err;
      o_abt[o_n]  <= out_abort;
      o_cyc[o_n]  <= cyc;
      o_n         <= o_n + 1;
    end
  end

  int         drv_cyc [1024];
  int         drv_n = 0;
  logic [7:0] frm [$];
  logic [7:0] fcs_b [$];
  logic [7:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_raw(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    if (drv_n < 1024) drv_cyc[drv_n] = cyc;
    drv_n++;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic put_data(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      put_raw(8'h7D);
      put_raw(b ^ 8'h20);
    end else begin
      put_raw(b);
    end
  endtask

  function automatic logic [31:0] ref_crc(input bit wide);
    logic [31:0] c;
    c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    foreach (frm[i]) begin
      c = c ^ {24'h0, frm[i]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408)) : (c >> 1);
    end
    return c;
  endfunction

  // flag, stuffed payload, optional CRC, flag, then a quiet window
  task automatic send_frame(input bit add_fcs, input bit wide, input bit bad);
    logic [31:0] f;
    f = ~ref_crc(wide);
    if (bad) f = f ^ 32'h1;
    fcs_b.delete();
    if (add_fcs) for (int k = 0; k < (wide ? 4 : 2); k++) fcs_b.push_back(f[8*k +: 8]);
    put_raw(8'h7E);
    foreach (frm[i]) put_data(frm[i]);
    foreach (fcs_b[i]) put_data(fcs_b[i]);
    put_raw(8'h7E);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int base,
                             input bit exp_err, input bit exp_abt);
    int n;
    n = o_n - base;
    chk(n == exp_q.size(), req, "byte count", n, exp_q.size());
    for (int i = 0; i < exp_q.size() && i < n; i++) begin
      bit last;
      last = (i == exp_q.size() - 1);
      chk(o_data[base+i] == exp_q[i], req, "data", o_data[base+i], exp_q[i]);
      chk(o_eof[base+i] == last, "R10", "eof", o_eof[base+i], last);
      chk(o_err[base+i] == (last && exp_err), req, "crc_err", o_err[base+i], last && exp_err);
      chk(o_abt[base+i] == (last && exp_abt), req, "abort", o_abt[base+i], last && exp_abt);
    end
  endtask

  task automatic set_cfg(input bit ce, input bit wide, input bit pass,
                         input logic [1:0] mode);
    @(negedge clk);
    crc_en = ce; crc_size = wide; crc_pass = pass; addr_mode = mode;
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R10", "valid after reset", out_valid, 0);
    chk(out_eof == 1'b0 && out_crc_err == 1'b0 && out_abort == 1'b0,
        "R10", "status after reset", {out_eof, out_crc_err, out_abort}, 0);
  endtask

  task automatic t_crc16_strip;
    int b;
    set_cfg(1, 0, 0, 2'b00);
    b = o_n;
    frm = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    send_frame(1, 0, 0);
    exp_q = frm;
    check_frame("R8", b, 0, 0);
  endtask

  task automatic t_crc32_pass;
    int b;
    set_cfg(1, 1, 1, 2'b00);
    b = o_n;
    frm = '{8'h5A, 8'hA5, 8'h0F};
    send_frame(1, 1, 0);
    exp_q = frm;
    foreach (fcs_b[i]) exp_q.push_back(fcs_b[i]);
    check_frame("R8", b, 0, 0);
  endtask

  task automatic t_crc32_strip;
    int b;
    set_cfg(1, 1, 0, 2'b00);
    b = o_n;
    frm = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
    send_frame(1, 1, 0);
    exp_q = frm;
    check_frame("R7", b, 0, 0);
  endtask

  task automatic t_crc_error;
    int b;
    set_cfg(1, 0, 0, 2'b00);
    b = o_n;
    frm = '{8'h10, 8'h20, 8'h30};
    send_frame(1, 0, 1);
    exp_q = frm;
    check_frame("R7", b, 1, 0);
    // same bytes with checking off: no error even though CRC is wrong
    set_cfg(0, 0, 0, 2'b00);
    b = o_n;
    frm = '{8'h10, 8'h20, 8'h30, 8'h99, 8'h98};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R7", b, 0, 0);
  endtask

  task automatic t_stuffing;
    int b;
    set_cfg(1, 0, 0, 2'b00);
    b = o_n;
    frm = '{8'h7E, 8'h11, 8'h7D, 8'h20, 8'h5E};
    send_frame(1, 0, 0);
    exp_q = frm;
    check_frame("R3", b, 0, 0);
  endtask

  task automatic t_addr_byte;
    int b;
    set_cfg(0, 0, 0, 2'b01);
    addr_cfg = 32'hD4C3_B2A1;
    b = o_n;
    frm = '{8'hC3, 8'h99};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R5", b, 0, 0);
    b = o_n;
    frm = '{8'h55, 8'h99};
    send_frame(0, 0, 0);
    exp_q.delete();
    check_frame("R5", b, 0, 0);
    b = o_n;
    frm = '{8'hD4};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R5", b, 0, 0);
  endtask

  task automatic t_addr_pair;
    int b;
    set_cfg(0, 0, 0, 2'b10);
    addr_cfg = 32'hBEEF_1234;
    b = o_n;
    frm = '{8'h12, 8'h34, 8'h55};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R6", b, 0, 0);
    b = o_n;
    frm = '{8'h34, 8'h12, 8'h55};
    send_frame(0, 0, 0);
    exp_q.delete();
    check_frame("R6", b, 0, 0);
    b = o_n;
    frm = '{8'hBE, 8'hEF};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R6", b, 0, 0);
    b = o_n;
    frm = '{8'h12};
    send_frame(0, 0, 0);
    exp_q.delete();
    check_frame("R6", b, 0, 0);
  endtask

  task automatic t_addr_reserved;
    int b;
    set_cfg(0, 0, 0, 2'b11);
    addr_cfg = 32'hD4C3_B2A1;
    b = o_n;
    frm = '{8'h55, 8'h66};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R4", b, 0, 0);
  endtask

  task automatic t_abort;
    int b;
    set_cfg(1, 0, 0, 2'b00);
    b = o_n;
    put_raw(8'h7E);
    put_raw(8'hA0);
    put_raw(8'hA1);
    put_raw(8'hA2);
    put_raw(8'h7D);
    put_raw(8'h7E);
    repeat (12) @(negedge clk);
    exp_q = '{8'hA0, 8'hA1, 8'hA2};
    check_frame("R9", b, 0, 1);
  endtask

  task automatic t_runt;
    int b;
    set_cfg(1, 0, 0, 2'b00);
    b = o_n;
    put_raw(8'h7E);
    put_raw(8'hAA);
    put_raw(8'hBB);
    put_raw(8'h7E);
    repeat (12) @(negedge clk);
    chk(o_n == b, "R11", "runt output count", o_n - b, 0);
  endtask

  task automatic t_empty_flags;
    int b;
    set_cfg(0, 0, 0, 2'b00);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    b = o_n;
    put_raw(8'h11);
    put_raw(8'h22);
    put_raw(8'h7E);
    put_raw(8'h7E);
    put_raw(8'h7E);
    repeat (12) @(negedge clk);
    chk(o_n == b, "R2", "output from junk and empty flags", o_n - b, 0);
    b = o_n;
    frm = '{8'h99};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R2", b, 0, 0);
  endtask

  task automatic t_disable;
    int b;
    set_cfg(0, 0, 0, 2'b00);
    rx_en = 1'b0;
    b = o_n;
    frm = '{8'h01, 8'h02, 8'h03};
    send_frame(0, 0, 0);
    chk(o_n == b, "R1", "output while disabled", o_n - b, 0);
    rx_en = 1'b1;
    b = o_n;
    put_raw(8'h7E);
    put_raw(8'h44);
    put_raw(8'h55);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    rx_en = 1'b1;
    frm = '{8'h66, 8'h77};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R1", b, 0, 0);
  endtask

  task automatic t_latency;
    int b, d0;
    set_cfg(0, 0, 0, 2'b00);
    b  = o_n;
    d0 = drv_n;
    frm = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
    send_frame(0, 0, 0);
    exp_q = frm;
    check_frame("R12", b, 0, 0);
    // drives: flag at d0, data at d0+1..d0+7, closing flag at d0+8
    if (o_n - b == 7) begin
      chk(o_cyc[b] == drv_cyc[d0+6] + 2, "R12", "first byte cycle",
          o_cyc[b], drv_cyc[d0+6] + 2);
      chk(o_cyc[b+1] == drv_cyc[d0+7] + 2, "R12", "second byte cycle",
          o_cyc[b+1], drv_cyc[d0+7] + 2);
      chk(o_cyc[b+2] == drv_cyc[d0+8] + 2, "R12", "release start cycle",
          o_cyc[b+2], drv_cyc[d0+8] + 2);
      chk(o_cyc[b+6] == drv_cyc[d0+8] + 6, "R12", "eof cycle",
          o_cyc[b+6], drv_cyc[d0+8] + 6);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    t_crc16_strip();
    t_crc32_pass();
    t_crc32_strip();
    t_crc_error();
    t_stuffing();
    t_addr_byte();
    t_addr_pair();
    t_addr_reserved();
    t_abort();
    t_runt();
    t_empty_flags();
    t_disable();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule